// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit holds the control state of a 32-bit RISC core and decides, cycle by cycle, whether the core must leave its instruction stream for the exception handler. It keeps the operating mode (user or supervisor) and a global interrupt enable. It keeps two saved copies of those bits, one for exceptions and one for debug breaks. It also keeps a per-line interrupt enable mask, shows which enabled lines are requesting, and returns a fixed processor identifier.

Each cycle the unit looks at the interrupt request lines, a trap request, an unimplemented-instruction request and any control-register access made from user mode. If one of these must be taken, it raises a take strobe in the same cycle. It also presents the handler address, a code for the winning cause, and the return address, which is the current PC plus four. On the next clock edge it saves the status bits and drops to supervisor mode with interrupts masked. Return strobes restore the status bits from either saved copy. The core reads and writes the control registers through a single port indexed by register number.

Top module: `exc_ctl_unit`

## Requirements
- R1: Control register 0 (status) holds PIE in bit 0 and the mode bit U in bit 1, where U=1 is user mode. A write keeps only bits 1:0, and bits 31:2 always read as zero.
- R2: After reset the unit is in supervisor mode with PIE=0. Status, exception-saved status (index 1), break-saved status (index 2) and the enable mask (index 3) all read zero, and no exception is signalled.
- R3: Index 4 reads as the bitwise AND of the request lines and the enable mask. Writes to index 4 have no effect.
- R4: An interrupt is taken only when PIE=1 and at least one request line has its mask bit set.
- R5: When an exception is taken, exc_take is high in that cycle, exc_target equals the HANDLER_ADDR parameter (default MEM_BASE + 0x20, which is 0x20), and exc_ret_addr equals cur_pc + 4. On the next edge index 1 receives the old status, and U and PIE are both cleared.
- R6: An eret strobe copies index 1 into status. A bret strobe copies index 2 into status.
- R7: A control-register read or write made in user mode raises an exception with cause code 3 and read data of zero. The write does not change the register.
- R8: Cause codes are 0 for interrupt, 1 for trap, 2 for unimplemented instruction and 3 for user-mode register access. When several causes are present in one cycle, the priority order is interrupt, then trap, then unimplemented, then user-mode access.
- R9: Index 5 reads the CPU_ID parameter and ignores writes. Indices 6 and 7 read zero.
- R10: An exception in a given cycle overrides an eret, a bret or a register write made in that same cycle. None of them has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NIRQ | Interrupt request lines |
| trap_req | input | 1 | Trap instruction request |
| unimpl_req | input | 1 | Unimplemented instruction request |
| cur_pc | input | XLEN | Address of the current instruction |
| eret_stb | input | 1 | Return from exception |
| bret_stb | input | 1 | Return from debug break |
| csr_rd_en | input | 1 | Control register read |
| csr_wr_en | input | 1 | Control register write |
| csr_idx | input | 3 | Control register number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, zero when not reading or in user mode |
| exc_take | output | 1 | Exception taken this cycle |
| exc_cause | output | 2 | Winning cause code, valid with exc_take |
| exc_target | output | XLEN | Handler address |
| exc_ret_addr | output | XLEN | Return address, cur_pc + 4 |

## Verification
A table of interrupt patterns varies PIE, the mask and the request lines independently. It covers a masked-out line, a disabled global enable, the top line alone, and disjoint mask and request sets, which separates the global gate from the per-line AND. Trap, unimplemented and user-access requests are applied alone and in combination, so the cause code exposes any swap in priority. Return strobes and register writes are applied in the same cycle as an exception. This shows that entry wins. Reads of the saved copy after a bret into user mode show that the status was saved and restored as a whole.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

  typedef enum logic [1:0] {
    CAUSE_IRQ    = 2'd0,
    CAUSE_TRAP   = 2'd1,
    CAUSE_UNIMPL = 2'd2,
    CAUSE_PRIV   = 2'd3
  } exc_cause_e;

  localparam int unsigned IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ESTAT   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_BSTAT   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_MASK    = 3'd3;
  localparam logic [IDX_W-1:0] IDX_PEND    = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CPUID   = 3'd5;

  typedef struct packed {
    logic usr;
    logic pie;
  } stat_t;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int unsigned NIRQ = 32
) (
  input  logic            pie_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] mask_i,
  output logic [NIRQ-1:0] pend_o,
  output logic            hit_o
);

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_line
      assign pend_o[g] = irq_i[g] & mask_i[g];
    end
  endgenerate

  assign hit_o = pie_i & (|pend_o);

endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_i,
  input  logic       trap_i,
  input  logic       unimpl_i,
  input  logic       priv_i,
  output logic       take_o,
  output exc_cause_e cause_o
);

  always_comb begin
    take_o  = 1'b1;
    cause_o = CAUSE_IRQ;
    if (irq_i) begin
      cause_o = CAUSE_IRQ;
    end else if (trap_i) begin
      cause_o = CAUSE_TRAP;
    end else if (unimpl_i) begin
      cause_o = CAUSE_UNIMPL;
    end else if (priv_i) begin
      cause_o = CAUSE_PRIV;
    end else begin
      take_o  = 1'b0;
    end
  end

  // R8: a trap never loses to an unimplemented or access request
  p_trap_over_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !irq_i) |-> (take_o && cause_o == CAUSE_TRAP));

  // R8: the interrupt wins against every other cause
  p_irq_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> (take_o && cause_o == CAUSE_IRQ));

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
  import exc_ctl_pkg::*;
#(
  parameter int unsigned       XLEN   = 32,
  parameter int unsigned       NIRQ   = 32,
  parameter logic [XLEN-1:0]   CPU_ID = 32'h1234_5678
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             eret_i,
  input  logic             bret_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [NIRQ-1:0]  pend_i,
  output logic [XLEN-1:0]  rdata_o,
  output logic             user_o,
  output logic             pie_o,
  output logic [NIRQ-1:0]  mask_o
);

  localparam int unsigned PAD = XLEN - NIRQ;

  stat_t            stat_q, stat_d;
  stat_t            estat_q, estat_d;
  stat_t            bstat_q, bstat_d;
  logic [NIRQ-1:0]  mask_q, mask_d;
  logic             stat_en, estat_en, bstat_en, mask_en;
  logic             wr_ok;
  logic [XLEN-1:0]  mask_ext, pend_ext;

  generate
    if (PAD > 0) begin : g_pad
      assign mask_ext = {{PAD{1'b0}}, mask_q};
      assign pend_ext = {{PAD{1'b0}}, pend_i};
    end else begin : g_nopad
      assign mask_ext = mask_q;
      assign pend_ext = pend_i;
    end
  endgenerate

  assign wr_ok = wr_en_i & ~stat_q.usr & ~take_i;

  // next-state: exception entry > eret > bret > register write
  always_comb begin
    stat_d   = stat_q;
    estat_d  = estat_q;
    bstat_d  = bstat_q;
    mask_d   = mask_q;
    stat_en  = 1'b0;
    estat_en = 1'b0;
    bstat_en = 1'b0;
    mask_en  = 1'b0;
    if (take_i) begin
      estat_d  = stat_q;
      estat_en = 1'b1;
      stat_d   = '0;
      stat_en  = 1'b1;
    end else if (eret_i) begin
      stat_d   = estat_q;
      stat_en  = 1'b1;
    end else if (bret_i) begin
      stat_d   = bstat_q;
      stat_en  = 1'b1;
    end else if (wr_ok) begin
      unique case (idx_i)
        IDX_STATUS: begin
          stat_d  = stat_t'(wdata_i[1:0]);
          stat_en = 1'b1;
        end
        IDX_ESTAT: begin
          estat_d  = stat_t'(wdata_i[1:0]);
          estat_en = 1'b1;
        end
        IDX_BSTAT: begin
          bstat_d  = stat_t'(wdata_i[1:0]);
          bstat_en = 1'b1;
        end
        IDX_MASK: begin
          mask_d  = wdata_i[NIRQ-1:0];
          mask_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      estat_q <= '0;
      bstat_q <= '0;
      mask_q  <= '0;
    end else begin
      if (stat_en)  stat_q  <= stat_d;
      if (estat_en) estat_q <= estat_d;
      if (bstat_en) bstat_q <= bstat_d;
      if (mask_en)  mask_q  <= mask_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && !stat_q.usr) begin
      unique case (idx_i)
        IDX_STATUS: rdata_o = {{(XLEN-2){1'b0}}, stat_q};
        IDX_ESTAT:  rdata_o = {{(XLEN-2){1'b0}}, estat_q};
        IDX_BSTAT:  rdata_o = {{(XLEN-2){1'b0}}, bstat_q};
        IDX_MASK:   rdata_o = mask_ext;
        IDX_PEND:   rdata_o = pend_ext;
        IDX_CPUID:  rdata_o = CPU_ID;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign user_o = stat_q.usr;
  assign pie_o  = stat_q.pie;
  assign mask_o = mask_q;

  // R5: entry lands in supervisor mode with interrupts masked
  p_entry_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!stat_q.usr && !stat_q.pie));

  // R5: the exception copy holds the status seen at entry
  p_entry_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (estat_q == $past(stat_q)));

  // R6: eret without a competing exception restores the saved copy
  p_eret_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !take_i) |=> (stat_q == $past(estat_q)));

  // R7: a user-mode write leaves the mask untouched
  p_user_write_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && stat_q.usr) |=> $stable(mask_q));

endmodule

// File: rtl/exc_ctl_unit.sv
module exc_ctl_unit
  import exc_ctl_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     NIRQ         = 32,
  parameter logic [XLEN-1:0] MEM_BASE     = '0,
  parameter logic [XLEN-1:0] HANDLER_ADDR = MEM_BASE + 32'h20,
  parameter logic [XLEN-1:0] CPU_ID       = 32'h1234_5678
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIRQ-1:0]  irq_lines,
  input  logic             trap_req,
  input  logic             unimpl_req,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic             eret_stb,
  input  logic             bret_stb,
  input  logic             csr_rd_en,
  input  logic             csr_wr_en,
  input  logic [2:0]       csr_idx,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             exc_take,
  output logic [1:0]       exc_cause,
  output logic [XLEN-1:0]  exc_target,
  output logic [XLEN-1:0]  exc_ret_addr
);

  localparam logic [XLEN-1:0] PC_STEP = 4;

  logic            user_q;
  logic            pie_q;
  logic [NIRQ-1:0] mask_q;
  logic [NIRQ-1:0] pend;
  logic            irq_hit;
  logic            priv_viol;
  exc_cause_e      cause;

  assign priv_viol = (csr_rd_en | csr_wr_en) & user_q;

  exc_irq_gate #(.NIRQ(NIRQ)) u_gate (
    .pie_i  (pie_q),
    .irq_i  (irq_lines),
    .mask_i (mask_q),
    .pend_o (pend),
    .hit_o  (irq_hit)
  );

  exc_cause_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_hit),
    .trap_i   (trap_req),
    .unimpl_i (unimpl_req),
    .priv_i   (priv_viol),
    .take_o   (exc_take),
    .cause_o  (cause)
  );

  exc_csr_file #(.XLEN(XLEN), .NIRQ(NIRQ), .CPU_ID(CPU_ID)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (exc_take),
    .eret_i  (eret_stb),
    .bret_i  (bret_stb),
    .rd_en_i (csr_rd_en),
    .wr_en_i (csr_wr_en),
    .idx_i   (csr_idx),
    .wdata_i (csr_wdata),
    .pend_i  (pend),
    .rdata_o (csr_rdata),
    .user_o  (user_q),
    .pie_o   (pie_q),
    .mask_o  (mask_q)
  );

  assign exc_cause    = cause;
  assign exc_target   = HANDLER_ADDR;
  assign exc_ret_addr = cur_pc + PC_STEP;

  // R7: any register access from user mode must trap
  p_user_access_traps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en || csr_wr_en) && user_q |-> (exc_take && csr_rdata == '0));

  // R4: an interrupt cause requires the global enable
  p_irq_needs_pie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_cause == 2'd0) |-> (pie_q && |(irq_lines & mask_q)));

endmodule

// File: tb/sim_exc_ctl_unit.sv
`timescale 1ns/1ps
module sim_exc_ctl_unit;

  localparam logic [31:0] CPU_ID  = 32'h1234_5678;
  localparam logic [31:0] HANDLER = 32'h0000_0020;

  logic        clk;
  logic        rst_n;
  logic [31:0] irq_lines;
  logic        trap_req, unimpl_req, eret_stb, bret_stb;
  logic [31:0] cur_pc;
  logic        csr_rd_en, csr_wr_en;
  logic [2:0]  csr_idx;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        exc_take;
  logic [1:0]  exc_cause;
  logic [31:0] exc_target, exc_ret_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] s_rdata, s_target, s_ret;
  logic        s_take;
  logic [1:0]  s_cause;

  // {pie, mask, irq, expected pending, expected take}
  localparam int NV = 6;
  localparam logic [97:0] VEC [NV] = '{
    {1'b1, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b1},
    {1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 1'b0},
    {1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
    {1'b1, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1},
    {1'b1, 32'h0000_FF00, 32'h0000_00FF, 32'h0000_0000, 1'b0},
    {1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  exc_ctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trap_req(trap_req),
    .unimpl_req(unimpl_req), .cur_pc(cur_pc), .eret_stb(eret_stb),
    .bret_stb(bret_stb), .csr_rd_en(csr_rd_en), .csr_wr_en(csr_wr_en),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .exc_take(exc_take), .exc_cause(exc_cause), .exc_target(exc_target),
    .exc_ret_addr(exc_ret_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_lines = '0; trap_req = 0; unimpl_req = 0; eret_stb = 0; bret_stb = 0;
    cur_pc = '0; csr_rd_en = 0; csr_wr_en = 0; csr_idx = '0; csr_wdata = '0;
  endtask

  task automatic step(input logic [2:0] idx, input logic rd, input logic wr,
                      input logic [31:0] wd, input logic [31:0] irq,
                      input logic trp, input logic uni, input logic er,
                      input logic br, input logic [31:0] pc);
    @(negedge clk);
    csr_idx = idx; csr_rd_en = rd; csr_wr_en = wr; csr_wdata = wd;
    irq_lines = irq; trap_req = trp; unimpl_req = uni;
    eret_stb = er; bret_stb = br; cur_pc = pc;
    #1;
    s_rdata = csr_rdata; s_take = exc_take; s_cause = exc_cause;
    s_target = exc_target; s_ret = exc_ret_addr;
    @(posedge clk);
    #1 clear_in();
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] v);
    step(idx, 0, 1, v, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic rd(input logic [2:0] idx);
    step(idx, 1, 0, '0, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R2 reset state
    rd(3'd0); check("R2 status", s_rdata, 0); check("R2 no take", {31'b0, s_take}, 0);
    rd(3'd1); check("R2 estatus", s_rdata, 0);
    rd(3'd2); check("R2 bstatus", s_rdata, 0);
    rd(3'd3); check("R2 mask", s_rdata, 0);
    // R9 identifier and unused indices
    rd(3'd5); check("R9 cpuid", s_rdata, CPU_ID);
    rd(3'd6); check("R9 idx6", s_rdata, 0);
    rd(3'd7); check("R9 idx7", s_rdata, 0);

    // R1 status layout
    wr(3'd0, 32'hFFFF_FFFD); rd(3'd0); check("R1 masked write", s_rdata, 32'h1);
    wr(3'd0, 32'hFFFF_FFFC); rd(3'd0); check("R1 clear", s_rdata, 32'h0);

    // R3 pending view, write ignored
    wr(3'd3, 32'h0000_00F0);
    step(3'd4, 0, 1, 32'hFFFF_FFFF, 32'h0, 0, 0, 0, 0, '0);
    step(3'd4, 1, 0, '0, 32'h0000_0030, 0, 0, 0, 0, '0);
    check("R3 pending", s_rdata, 32'h30);
    check("R4 no take pie0", {31'b0, s_take}, 0);
    wr(3'd5, 32'h0); rd(3'd5); check("R9 cpuid write ignored", s_rdata, CPU_ID);

    // R4 vector table
    for (int i = 0; i < NV; i++) begin
      logic [97:0] v;
      v = VEC[i];
      wr(3'd0, {31'b0, v[97]});
      wr(3'd3, v[96:65]);
      step(3'd4, 1, 0, '0, v[64:33], 0, 0, 0, 0, 32'h1000 + 32'(i * 16));
      check($sformatf("R3 vec%0d pending", i), s_rdata, v[32:1]);
      check($sformatf("R4 vec%0d take", i), {31'b0, s_take}, {31'b0, v[0]});
      if (v[0]) begin
        check($sformatf("R8 vec%0d cause", i), {30'b0, s_cause}, 0);
        check($sformatf("R5 vec%0d ret", i), s_ret, 32'h1000 + 32'(i * 16) + 4);
        rd(3'd0); check($sformatf("R5 vec%0d status", i), s_rdata, 0);
        rd(3'd1); check($sformatf("R5 vec%0d estatus", i), s_rdata, 32'h1);
      end
    end

    // R5 trap entry
    wr(3'd0, 32'h1);
    step(3'd0, 0, 0, '0, '0, 1, 0, 0, 0, 32'h2000);
    check("R5 take", {31'b0, s_take}, 1);
    check("R8 trap cause", {30'b0, s_cause}, 1);
    check("R5 target", s_target, HANDLER);
    check("R5 ret", s_ret, 32'h2004);
    rd(3'd0); check("R5 status cleared", s_rdata, 0);
    rd(3'd1); check("R5 estatus", s_rdata, 32'h1);

    // R6 eret and bret
    step(3'd0, 0, 0, '0, '0, 0, 0, 1, 0, '0);
    rd(3'd0); check("R6 eret", s_rdata, 32'h1);
    wr(3'd2, 32'h3);
    step(3'd0, 0, 0, '0, '0, 0, 0, 0, 1, '0);
    // now in user mode: R7 read
    rd(3'd0);
    check("R7 user read take", {31'b0, s_take}, 1);
    check("R7 user read cause", {30'b0, s_cause}, 3);
    check("R7 user read data", s_rdata, 0);
    rd(3'd0); check("R5 back to supervisor", s_rdata, 0);
    rd(3'd1); check("R6 bret restored U and PIE", s_rdata, 32'h3);

    // R7 user write blocked
    wr(3'd3, 32'h0000_00AA);
    step(3'd0, 0, 0, '0, '0, 0, 0, 1, 0, '0);
    wr(3'd3, 32'hFFFF_FFFF);
    check("R7 user write take", {31'b0, s_take}, 1);
    check("R7 user write cause", {30'b0, s_cause}, 3);
    rd(3'd3); check("R7 mask unchanged", s_rdata, 32'hAA);

    // R8 priority
    wr(3'd3, 32'h1); wr(3'd0, 32'h1);
    step(3'd0, 0, 0, '0, 32'h1, 1, 1, 0, 0, '0);
    check("R8 irq beats all", {30'b0, s_cause}, 0);
    step(3'd0, 0, 0, '0, '0, 1, 1, 0, 0, '0);
    check("R8 trap beats unimpl", {30'b0, s_cause}, 1);
    step(3'd0, 0, 0, '0, '0, 0, 1, 0, 0, '0);
    check("R8 unimpl alone", {30'b0, s_cause}, 2);
    wr(3'd1, 32'h2);
    step(3'd0, 0, 0, '0, '0, 0, 0, 1, 0, '0);
    step(3'd0, 1, 0, '0, '0, 0, 1, 0, 0, '0);
    check("R8 unimpl beats user access", {30'b0, s_cause}, 2);

    // R10 exception overrides same-cycle actions
    wr(3'd1, 32'h1); wr(3'd0, 32'h0);
    step(3'd0, 0, 0, '0, '0, 1, 0, 1, 0, '0);
    rd(3'd0); check("R10 eret suppressed", s_rdata, 0);
    rd(3'd1); check("R10 estatus from entry", s_rdata, 0);
    wr(3'd3, 32'h55);
    step(3'd3, 0, 1, 32'h77, '0, 1, 0, 0, 0, '0);
    rd(3'd3); check("R10 write suppressed", s_rdata, 32'h55);
    wr(3'd2, 32'h3);
    step(3'd0, 0, 0, '0, '0, 0, 1, 0, 1, '0);
    rd(3'd0); check("R10 bret suppressed", s_rdata, 0);

    finish_run();
  end

endmodule